// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of a classic byte-oriented asynchronous serial port. Software writes characters into a small circular holding buffer. Whenever the shifter is idle and a character is waiting, the block moves the oldest character into the shifter. The shifter then sends it as one asynchronous frame on a single line that idles high.

The frame shape comes from static control inputs: 5 to 8 data bits, an optional parity bit (even, odd or forced to one) and one or two stop bits. Bit timing comes from an external divider that pulses `bitTick` once per bit period. Two status flags show the hand-off between buffer and shifter, and an empty-buffer interrupt request goes with them. A break input forces the line low and replaces characters with break frames. A loopback input keeps the line high and delivers each finished character on a parallel port instead.

Top module: `txline_core`

## Requirements
- R1: After reset `holdEmpty`=1, `shiftEmpty`=1, `threIrq`=0, `loopValid`=0 and `txOut`=1.
- R2: A frame is sent least significant bit first: one 0 start bit, then `wordLen`+5 data bits (`wordLen` 0..3 gives 5..8), then the parity bit if `parityOn`=1, then one 1 stop bit, plus a second 1 stop bit when `twoStop`=1. Each bit stays on `txOut` until the next `bitTick` cycle. The start bit begins in the cycle after the load.
- R3: With `parityStick`=1 the parity bit is 1. Otherwise it is the XOR of the sent data bits when `parityEven`=1, and the inverse of that XOR when `parityEven`=0.
- R4: A write (`wrEn`=1 at a rising edge, no `fifoClr`) makes `holdEmpty` 0 and `threIrq` 0 from the next cycle.
- R5: When the shifter is idle and the buffer holds a character, the next edge moves the oldest character into the shifter and clears `shiftEmpty`. If the buffer is then empty and no write happens in the same cycle, `holdEmpty` and `threIrq` become 1.
- R6: On the edge of a frame's last tick, `shiftEmpty` becomes 1 if the buffer is empty. Otherwise the next character loads on the following edge, so the line spends one cycle high between frames.
- R7: A write to a full buffer (DEPTH characters) stores the data in the slot at the write pointer and does not advance the pointer or change the count. In a full circular buffer that slot holds the oldest waiting character, so the new character replaces it in the send order.
- R8: `fifoClr` empties the buffer and sets `holdEmpty` on the next edge. It blocks a load in the same cycle. A frame already in the shifter still completes.
- R9: While `breakOn`=1 and `loopOn`=0, `txOut` is 0. A character that loads while `breakOn`=1 is used up as a break frame of the full frame length and is never sent. Setting `breakOn` during a normal frame aborts that frame and starts a full-length break frame.
- R10: Clearing `breakOn` during a break frame ends it on the next edge. The shifter is then idle, and a waiting character loads one edge later.
- R11: While `loopOn`=1, `txOut` stays 1. On the edge that ends a normal frame, the character (masked to the word length) appears on `loopData`, and `loopValid` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Character to write |
| fifoClr | input | 1 | Empty the holding buffer |
| wordLen | input | 2 | Data bits minus 5 |
| parityOn | input | 1 | Append a parity bit |
| parityEven | input | 1 | Even (1) or odd (0) parity |
| parityStick | input | 1 | Force the parity bit to 1 |
| twoStop | input | 1 | Add a second stop bit |
| breakOn | input | 1 | Send break instead of characters |
| loopOn | input | 1 | Loop characters back internally |
| bitTick | input | 1 | One pulse per bit period |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding buffer empty |
| shiftEmpty | output | 1 | Shifter idle and buffer empty |
| threIrq | output | 1 | Buffer-empty interrupt request |
| loopData | output | 8 | Last looped-back character |
| loopValid | output | 1 | One-cycle pulse with new `loopData` |

## Verification
The hardest state to reach is a full buffer that takes one more write, because the send order it produces only shows after several complete frames. The stimulus gets there by holding `bitTick` low, so the first character stays parked in the shifter while writes fill the buffer and overflow it. It then turns on loopback and ticks every frame out, reading each character from `loopData`. A break that arrives in mid-frame and is withdrawn in mid-break is reached the same way: the bench counts a few ticks by hand, toggles `breakOn`, and queues a character so it can see the shifter resume.

// File: rtl/txline_pkg.sv
package txline_pkg;
  localparam int DW = 8;   // widest character
  localparam int FW = 12;  // start + 8 data + parity + 2 stop
  localparam int LW = 4;   // frame length counter width

  typedef struct packed {
    logic load;   // move oldest character into shifter
    logic shift;  // advance one serial bit
    logic emit;   // normal frame finished
  } txStrobe_t;
endpackage

// File: rtl/txline_ctrl.sv
module txline_ctrl
  import txline_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          fifoClr,
  input  logic          bitTick,
  input  logic          breakOn,
  input  logic [CW-1:0] bufCount,
  input  logic [LW-1:0] frameLen,
  output txStrobe_t     strb,
  output logic          busy,
  output logic          brkMode,
  output logic          holdEmpty,
  output logic          shiftEmpty,
  output logic          threIrq
);
  logic [LW-1:0] bitsLeft;
  logic bufHas, lastOne, brkStart, brkEnd, lastTick;

  always_comb begin
    bufHas   = (bufCount != '0);
    lastOne  = (bufCount == CW'(1));
    brkEnd   = busy && brkMode && !breakOn;
    brkStart = busy && !brkMode && breakOn;
    lastTick = busy && bitTick && (bitsLeft == LW'(1)) && !brkEnd && !brkStart;
    strb.load  = !busy && bufHas && !fifoClr;
    strb.shift = busy && bitTick && !brkMode && !brkStart;
    strb.emit  = lastTick && !brkMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      brkMode  <= 1'b0;
      bitsLeft <= '0;
    end else if (strb.load) begin
      busy     <= 1'b1;
      brkMode  <= breakOn;
      bitsLeft <= frameLen;
    end else if (brkEnd) begin
      busy    <= 1'b0;
      brkMode <= 1'b0;
    end else if (brkStart) begin
      brkMode  <= 1'b1;
      bitsLeft <= frameLen;
    end else if (busy && bitTick) begin
      if (bitsLeft == LW'(1)) begin
        busy    <= 1'b0;
        brkMode <= 1'b0;
      end else begin
        bitsLeft <= bitsLeft - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdEmpty  <= 1'b1;
      shiftEmpty <= 1'b1;
      threIrq    <= 1'b0;
    end else begin
      if (fifoClr)                    holdEmpty <= 1'b1;
      else if (wrEn)                  holdEmpty <= 1'b0;
      else if (strb.load && lastOne)  holdEmpty <= 1'b1;

      if (wrEn)                       threIrq <= 1'b0;
      else if (strb.load && lastOne)  threIrq <= 1'b1;

      if (strb.load)                                        shiftEmpty <= 1'b0;
      else if ((lastTick || brkEnd) && (!bufHas || fifoClr)) shiftEmpty <= 1'b1;
      else if (!busy && !bufHas)                            shiftEmpty <= 1'b1;
    end
  end
endmodule

// File: rtl/txline_dp.sv
module txline_dp
  import txline_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          fifoClr,
  input  logic [1:0]    wordLen,
  input  logic          parityOn,
  input  logic          parityEven,
  input  logic          parityStick,
  input  logic          twoStop,
  input  logic          loopOn,
  input  txStrobe_t     strb,
  output logic [CW-1:0] bufCount,
  output logic [LW-1:0] frameLen,
  output logic          serBit,
  output logic [DW-1:0] loopData,
  output logic          loopValid
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [FW-1:0] shReg, frm;
  logic [DW-1:0] curChar, headChar, dataMask;
  logic          parBit, full, pushAdv;
  int            nData;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    nData    = int'(wordLen) + 5;
    headChar = mem[tail];
    dataMask = DW'((1 << nData) - 1);
    parBit   = parityStick ? 1'b1 :
               (parityEven ? ^(headChar & dataMask) : ~^(headChar & dataMask));
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < nData) frm[1 + i] = headChar[i];
    if (parityOn) frm[1 + nData] = parBit;
    frameLen = LW'(2 + nData + int'(parityOn) + int'(twoStop));
    full     = (bufCount == CW'(DEPTH));
    pushAdv  = wrEn && !full;
    serBit   = shReg[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head <= '0; tail <= '0; bufCount <= '0;
    end else if (fifoClr) begin
      head <= '0; tail <= '0; bufCount <= '0;
    end else begin
      if (pushAdv)   head <= nextPtr(head);
      if (strb.load) tail <= nextPtr(tail);
      bufCount <= bufCount + CW'(pushAdv) - CW'(strb.load);
    end
  end

  always_ff @(posedge clk)
    if (wrEn && !fifoClr) mem[head] <= wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '1;
      curChar   <= '0;
      loopData  <= '0;
      loopValid <= 1'b0;
    end else begin
      loopValid <= 1'b0;
      if (strb.load) begin
        shReg   <= frm;
        curChar <= headChar & dataMask;
      end else if (strb.shift) begin
        shReg <= {1'b1, shReg[FW-1:1]};
      end
      if (strb.emit && loopOn) begin
        loopData  <= curChar;
        loopValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txline_core.sv
module txline_core
  import txline_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       fifoClr,
  input  logic [1:0] wordLen,
  input  logic       parityOn,
  input  logic       parityEven,
  input  logic       parityStick,
  input  logic       twoStop,
  input  logic       breakOn,
  input  logic       loopOn,
  input  logic       bitTick,
  output logic       txOut,
  output logic       holdEmpty,
  output logic       shiftEmpty,
  output logic       threIrq,
  output logic [7:0] loopData,
  output logic       loopValid
);
  localparam int CW = $clog2(DEPTH + 1);

  txStrobe_t     strb;
  logic [CW-1:0] bufCount;
  logic [LW-1:0] frameLen;
  logic          busy, brkMode, serBit;

  txline_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .fifoClr(fifoClr), .bitTick(bitTick),
    .breakOn(breakOn), .bufCount(bufCount), .frameLen(frameLen), .strb(strb),
    .busy(busy), .brkMode(brkMode), .holdEmpty(holdEmpty),
    .shiftEmpty(shiftEmpty), .threIrq(threIrq)
  );

  txline_dp #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .fifoClr(fifoClr),
    .wordLen(wordLen), .parityOn(parityOn), .parityEven(parityEven),
    .parityStick(parityStick), .twoStop(twoStop), .loopOn(loopOn), .strb(strb),
    .bufCount(bufCount), .frameLen(frameLen), .serBit(serBit),
    .loopData(loopData), .loopValid(loopValid)
  );

  always_comb begin
    if (loopOn)                  txOut = 1'b1;
    else if (breakOn || brkMode) txOut = 1'b0;
    else if (busy)               txOut = serBit;
    else                         txOut = 1'b1;
  end
endmodule

// File: rtl/txline_chk.sv
module txline_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       fifoClr,
  input logic       breakOn,
  input logic       loopOn,
  input logic       txOut,
  input logic       holdEmpty,
  input logic       threIrq,
  input logic       loopValid
);
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !fifoClr |=> !holdEmpty); // R4
  AST_WRITE_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !threIrq); // R4
  AST_IRQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(threIrq) |-> holdEmpty); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> holdEmpty); // R8
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    breakOn && !loopOn |-> !txOut); // R9
  AST_LOOP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    loopOn |-> txOut); // R11
  AST_LOOP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loopValid |-> $past(loopOn)); // R11
endmodule

bind txline_core txline_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .fifoClr(fifoClr), .breakOn(breakOn),
  .loopOn(loopOn), .txOut(txOut), .holdEmpty(holdEmpty), .threIrq(threIrq),
  .loopValid(loopValid)
);

// File: tb/txline_core_tb.sv
module txline_core_tb;
  localparam int DEPTH = 4;

  logic clk, rstN, wrEn, fifoClr, parityOn, parityEven, parityStick, twoStop;
  logic breakOn, loopOn, bitTick, txOut, holdEmpty, shiftEmpty, threIrq, loopValid;
  logic [7:0] wrData, loopData;
  logic [1:0] wordLen;

  txline_core #(.DEPTH(DEPTH)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // {wordLen, parityOn, parityEven, parityStick, twoStop, data}
  localparam logic [13:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA7},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA7},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h1F},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7F},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] d);
    wrEn = 1'b1; wrData = d; cyc(); wrEn = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int k = 0; k < n; k++) begin
      bitTick = 1'b1; cyc(); bitTick = 1'b0;
      if (k != n - 1) cyc();
    end
  endtask

  task automatic setCfg(input logic [13:0] v);
    wordLen = v[13:12]; parityOn = v[11]; parityEven = v[10];
    parityStick = v[9]; twoStop = v[8];
  endtask

  function automatic logic [11:0] expFrame(input logic [13:0] v, output int len);
    int n, idx;
    logic p;
    logic [11:0] b;
    n = int'(v[13:12]) + 5;
    b = '1; b[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin b[1 + i] = v[i]; p ^= v[i]; end
    idx = 1 + n;
    if (v[11]) begin
      b[idx] = v[9] ? 1'b1 : (v[10] ? p : ~p);
      idx++;
    end
    len = idx + 1 + int'(v[8]);
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; fifoClr = 1'b0; breakOn = 1'b0;
    loopOn = 1'b0; bitTick = 1'b0;
    setCfg(14'h3000);
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    check("R1 holdEmpty", holdEmpty, 1);
    check("R1 shiftEmpty", shiftEmpty, 1);
    check("R1 threIrq", threIrq, 0);
    check("R1 txOut", txOut, 1);
    check("R1 loopValid", loopValid, 0);

    // R4/R5/R6 hand-off
    writeChar(8'h41);
    check("R4 holdEmpty after write", holdEmpty, 0);
    check("R4 shiftEmpty before load", shiftEmpty, 1);
    cyc();
    check("R5 holdEmpty after load", holdEmpty, 1);
    check("R5 threIrq after load", threIrq, 1);
    check("R5 shiftEmpty after load", shiftEmpty, 0);
    check("R2 start bit", txOut, 0);
    writeChar(8'h42);
    check("R4 threIrq cleared", threIrq, 0);
    check("R4 holdEmpty cleared", holdEmpty, 0);
    tickN(10);
    check("R6 shiftEmpty stays low", shiftEmpty, 0);
    check("R6 idle cycle", txOut, 1);
    cyc();
    check("R6 next start bit", txOut, 0);
    check("R6 holdEmpty after reload", holdEmpty, 1);
    tickN(10);
    check("R6 shiftEmpty at end", shiftEmpty, 1);

    // R2/R3 frame table
    foreach (VEC[e]) begin
      int len;
      logic [11:0] ef;
      setCfg(VEC[e]);
      ef = expFrame(VEC[e], len);
      writeChar(VEC[e][7:0]);
      cyc();
      for (int k = 0; k < len; k++) begin
        check(VEC[e][11] ? "R3 frame bit" : "R2 frame bit", txOut, ef[k]);
        bitTick = 1'b1; cyc(); bitTick = 1'b0;
        if (k != len - 1) cyc();
      end
      check("R6 empty after frame", shiftEmpty, 1);
      check("R2 line idles high", txOut, 1);
      cyc();
    end

    // R7/R11 overwrite of full buffer, observed through loopback
    setCfg(14'h3000);
    loopOn = 1'b1;
    cyc();
    wrEn = 1'b1;
    wrData = 8'hA0; cyc();
    wrData = 8'hB1; cyc();
    wrData = 8'hC2; cyc();
    wrData = 8'hD3; cyc();
    wrData = 8'hE4; cyc();
    wrData = 8'hF5; cyc();
    wrEn = 1'b0;
    check("R11 line high in loopback", txOut, 1);
    check("R7 holdEmpty while full", holdEmpty, 0);
    begin
      logic [7:0] order [5];
      order = '{8'hA0, 8'hF5, 8'hC2, 8'hD3, 8'hE4};
      for (int f = 0; f < 5; f++) begin
        tickN(10);
        check("R11 loopValid", loopValid, 1);
        check("R7 send order", loopData, order[f]);
        cyc();
        check("R11 loopValid one cycle", loopValid, 0);
      end
    end
    check("R6 empty after drain", shiftEmpty, 1);
    loopOn = 1'b0;
    cyc();

    // R8 clear while a frame is in flight
    writeChar(8'h11);
    writeChar(8'h22);
    writeChar(8'h33);
    fifoClr = 1'b1; cyc(); fifoClr = 1'b0;
    check("R8 holdEmpty after clear", holdEmpty, 1);
    check("R8 frame continues", shiftEmpty, 0);
    tickN(10);
    check("R8 shiftEmpty after frame", shiftEmpty, 1);
    repeat (3) cyc();
    check("R8 no further load", shiftEmpty, 1);

    // R8 clear cancels a pending load
    writeChar(8'h44);
    fifoClr = 1'b1; cyc(); fifoClr = 1'b0;
    check("R8 pending load cancelled", shiftEmpty, 1);
    check("R8 txOut idle", txOut, 1);
    check("R8 no irq from cleared char", threIrq, 0);

    // R9 break while idle and break consuming a character
    breakOn = 1'b1; #1;
    check("R9 idle break low", txOut, 0);
    cyc();
    writeChar(8'h55);
    cyc();
    check("R9 break frame busy", shiftEmpty, 0);
    check("R9 break frame low", txOut, 0);
    tickN(9);
    check("R9 full-length break", shiftEmpty, 0);
    tickN(1);
    check("R9 break frame done", shiftEmpty, 1);
    breakOn = 1'b0; #1;
    check("R9 line released", txOut, 1);
    repeat (3) cyc();
    check("R9 character used up", shiftEmpty, 1);

    // R9/R10 abort a frame, then withdraw the break
    writeChar(8'h66);
    cyc();
    tickN(3);
    cyc();
    breakOn = 1'b1; #1;
    check("R9 abort drives low", txOut, 0);
    writeChar(8'h77);
    tickN(2);
    cyc();
    breakOn = 1'b0;
    cyc();
    check("R10 break ended", txOut, 1);
    check("R10 char waiting", shiftEmpty, 0);
    cyc();
    check("R10 next start bit", txOut, 0);
    tickN(10);
    check("R10 resumed frame done", shiftEmpty, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule